// File: doc/BRIEF.md
# Short Conditional Branch Sequencer

This block walks an instruction stream held in a byte-addressed program memory and keeps the program counter. It knows three opcodes: a one-byte no-operation and two short conditional jumps. Each jump is an opcode byte followed by a signed 8-bit displacement. The block reads the opcode. When that opcode needs a displacement, it reads that byte too. It then tests the condition flags supplied from outside and writes the next program counter.

A taken jump lands at the address of the byte that follows the whole two-byte instruction, plus the sign-extended displacement. A displacement of 0xFE therefore gives a jump to itself, and 0x00 gives the next instruction. Any other opcode raises a sticky illegal flag and stops the sequencer until the next reset. The memory has a read latency of one cycle: a byte comes back in the cycle after its address was presented.

Top module: `bseq_core`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `pc` and `rd_addr` equal `start_addr`, and both `branch_taken` and `illegal_op` are 0.
- R2: The block presents `pc` on `rd_addr` to fetch an opcode. In the next cycle it presents `pc`+1, so that the displacement comes back while the opcode is decoded. `rd_data` is taken to be the byte at the address presented one cycle earlier.
- R3: Opcode 0x90 is a no-operation. It advances `pc` by 1, and the next opcode fetch starts two cycles after the previous one.
- R4: Opcode 0x7E jumps when zero=1 or sign≠overflow. Opcode 0x7F jumps when zero=0 and sign=overflow. The flags are sampled in the cycle in which the displacement byte is on `rd_data`.
- R5: A taken jump loads `pc` with opcode address + 2 + sign-extended displacement, and `branch_taken` is 1 for exactly the cycle in which that new `pc` first appears. A displacement of 0xFE returns to the same opcode address, and 0x00 gives opcode address + 2.
- R6: A jump that is not taken advances `pc` by 2, and `branch_taken` stays 0.
- R7: `pc` is PC_W bits wide (default 32). Target and sequential arithmetic wrap modulo 2^PC_W in both directions.
- R8: Any opcode byte other than 0x90, 0x7E or 0x7F sets `illegal_op` in the following cycle. From then on `illegal_op` stays 1, and `pc` and `rd_addr` hold their values until reset.
- R9: A jump takes three cycles, from its opcode fetch to the update of `pc`. `pc` never changes in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_addr | input | PC_W | Program counter value loaded during reset |
| rd_data | input | 8 | Byte returned by program memory, one cycle after its address |
| flag_zero | input | 1 | Zero condition flag |
| flag_sign | input | 1 | Sign condition flag |
| flag_ovf | input | 1 | Overflow condition flag |
| rd_addr | output | PC_W | Program memory read address |
| pc | output | PC_W | Address of the current instruction |
| branch_taken | output | 1 | One-cycle pulse when a jump loads its target |
| illegal_op | output | 1 | Sticky flag for an unknown opcode |

## Verification
The bench checks the origin of the target arithmetic with the exact cases that matter. These are a displacement of 0x0D taken from 0x9C, a self-loop at 0xFE, and a fall-through at 0x00. A design that measured from the opcode address would land two bytes early, and a design that missed the sign extension would fly forward instead of looping. Jumps that cross the top of the 32-bit space in both directions expose a truncated adder. The illegal case checks that the block stops on the unknown byte and keeps `pc` and `rd_addr` frozen over many cycles, where a faulty design would keep fetching. A long run over a memory filled only with legal bytes, under pseudo-random flags, covers every flag combination for both jump conditions and landings in the middle of an instruction. In that run a swapped condition or a one-cycle slip in the fetch timing shows up as a divergence from the cycle model.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        ST_FETCH_OP,
        ST_FETCH_DISP,
        ST_EXECUTE,
        ST_HALT
    } seq_state_e;

    typedef enum logic {
        COND_LE,
        COND_GT
    } cond_e;

    localparam int          BYTE_W   = 8;
    localparam logic [7:0]  OPC_NOP  = 8'h90;
    localparam logic [7:0]  OPC_JLE  = 8'h7E;
    localparam logic [7:0]  OPC_JG   = 8'h7F;

endpackage

// File: rtl/bseq_cond.sv
module bseq_cond
    import bseq_pkg::*;
(
    input  cond_e sel,
    input  logic  zf,
    input  logic  sf,
    input  logic  of,
    output logic  take
);
    logic less_eq;
    logic greater;

    always_comb begin
        less_eq = zf | (sf ^ of);
        greater = ~zf & ~(sf ^ of);
        take    = (sel == COND_GT) ? greater : less_eq;
    end
endmodule

// File: rtl/bseq_target.sv
module bseq_target #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] op_addr,
    input  logic [7:0]      disp,
    output logic [PC_W-1:0] seq_next,
    output logic [PC_W-1:0] jump_tgt
);
    localparam int            EXT_W     = PC_W - 8;
    localparam logic [PC_W-1:0] INSTR_LEN = PC_W'(2);

    logic [PC_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[7]}}, disp};
        seq_next = op_addr + INSTR_LEN;
        jump_tgt = seq_next + disp_ext;
    end
endmodule

// File: rtl/bseq_core.sv
module bseq_core
    import bseq_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] start_addr,
    input  logic [7:0]      rd_data,
    input  logic            flag_zero,
    input  logic            flag_sign,
    input  logic            flag_ovf,
    output logic [PC_W-1:0] rd_addr,
    output logic [PC_W-1:0] pc,
    output logic            branch_taken,
    output logic            illegal_op
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    typedef struct packed {
        seq_state_e      state;
        logic [PC_W-1:0] pc;
        cond_e           cond;
        logic            taken;
        logic            illegal;
    } seq_regs_t;

    seq_regs_t s_d;
    seq_regs_t s_q;

    logic            cond_true;
    logic [PC_W-1:0] seq_next;
    logic [PC_W-1:0] jump_tgt;
    logic [1:0]      state_w;

    bseq_cond u_cond (
        .sel  (s_q.cond),
        .zf   (flag_zero),
        .sf   (flag_sign),
        .of   (flag_ovf),
        .take (cond_true)
    );

    bseq_target #(.PC_W(PC_W)) u_target (
        .op_addr  (s_q.pc),
        .disp     (rd_data),
        .seq_next (seq_next),
        .jump_tgt (jump_tgt)
    );

    always_comb begin
        s_d       = s_q;
        s_d.taken = 1'b0;
        unique case (s_q.state)
            ST_FETCH_OP: begin
                s_d.state = ST_FETCH_DISP;
            end
            ST_FETCH_DISP: begin
                if (rd_data == OPC_NOP) begin
                    s_d.pc    = s_q.pc + ONE;
                    s_d.state = ST_FETCH_OP;
                end else if (rd_data == OPC_JLE || rd_data == OPC_JG) begin
                    s_d.cond  = (rd_data == OPC_JG) ? COND_GT : COND_LE;
                    s_d.state = ST_EXECUTE;
                end else begin
                    s_d.illegal = 1'b1;
                    s_d.state   = ST_HALT;
                end
            end
            ST_EXECUTE: begin
                if (cond_true) begin
                    s_d.pc    = jump_tgt;
                    s_d.taken = 1'b1;
                end else begin
                    s_d.pc    = seq_next;
                end
                s_d.state = ST_FETCH_OP;
            end
            default: begin
                s_d.state = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state   <= ST_FETCH_OP;
            s_q.pc      <= start_addr;
            s_q.cond    <= COND_LE;
            s_q.taken   <= 1'b0;
            s_q.illegal <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_addr      = (s_q.state == ST_FETCH_DISP) ? (s_q.pc + ONE) : s_q.pc;
        pc           = s_q.pc;
        branch_taken = s_q.taken;
        illegal_op   = s_q.illegal;
        state_w      = s_q.state;
    end
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
    import bseq_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pc,
    input logic [PC_W-1:0] rd_addr,
    input logic [7:0]      rd_data,
    input logic            branch_taken,
    input logic            illegal_op,
    input logic [1:0]      state_w
);
    // R8: once raised the illegal flag never drops before reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> illegal_op);

    // R8: a halted sequencer holds its counter and its read address
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> ($stable(pc) && $stable(rd_addr)));

    // R5: the taken pulse lasts a single cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |=> !branch_taken);

    // R9: no two consecutive counter updates
    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |=> $stable(pc));

    // R2: after the opcode address, the displacement address follows
    a_r2_disp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == 2'(ST_FETCH_OP)) |=> (rd_addr == $past(rd_addr) + PC_W'(1)));

    // R3: a decoded no-operation moves the counter by one
    a_r3_nop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == 2'(ST_FETCH_DISP) && rd_data == OPC_NOP) |=> (pc == $past(pc) + PC_W'(1)));

    // R6: an update without a taken pulse is a sequential step of 1 or 2
    a_r6_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pc) && !branch_taken) |->
            (pc == $past(pc) + PC_W'(1) || pc == $past(pc) + PC_W'(2)));
endmodule

bind bseq_core bseq_chk #(.PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc           (pc),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .branch_taken (branch_taken),
    .illegal_op   (illegal_op),
    .state_w      (state_w)
);

// File: tb/sim_bseq_core.sv
`timescale 1ns/1ps
module sim_bseq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] start_addr = 32'h0;
    logic [7:0]  rd_data = 8'h90;
    logic        fz = 1'b0, fs = 1'b0, fv = 1'b0;
    logic [31:0] rd_addr, pc;
    logic        branch_taken, illegal_op;

    logic [7:0]  mem [256];
    logic        flag_rand = 1'b0;
    logic [2:0]  f_fix = 3'b000;
    logic [15:0] lfsr = 16'hACE1;

    int n_cmp = 0;
    int n_bad = 0;
    int n_taken_seen = 0;

    // reference model state
    int          mph = 0;       // 0 opcode fetch, 1 decode, 2 execute, 3 halted
    logic [31:0] m_pc = 0;
    logic        m_taken = 0, m_ill = 0;
    logic [7:0]  m_op = 0;
    string       m_tag = "R1";

    always #4 clk = ~clk;

    bseq_core #(.PC_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .rd_data(rd_data),
        .flag_zero(fz), .flag_sign(fs), .flag_ovf(fv),
        .rd_addr(rd_addr), .pc(pc), .branch_taken(branch_taken), .illegal_op(illegal_op)
    );

    always @(posedge clk) rd_data <= mem[rd_addr[7:0]];

    // cycle model: compare, drive flags, then advance for the coming edge
    always @(negedge clk) begin
        logic [31:0] exp_addr;
        logic [7:0]  b;
        logic        le, gt, go;
        if (!rst_n) begin
            m_pc = start_addr; mph = 0; m_taken = 0; m_ill = 0; m_tag = "R1";
            {fz, fs, fv} = f_fix;
        end else begin
            exp_addr = (mph == 1) ? m_pc + 32'd1 : m_pc;
            n_cmp++;
            if (pc !== m_pc || rd_addr !== exp_addr || branch_taken !== m_taken || illegal_op !== m_ill) begin
                n_bad++;
                $display("FAIL %s model: pc=%h/%h addr=%h/%h taken=%b/%b ill=%b/%b (actual/expected)",
                         m_tag, pc, m_pc, rd_addr, exp_addr, branch_taken, m_taken, illegal_op, m_ill);
            end
            if (branch_taken === 1'b1) n_taken_seen++;
            if (flag_rand) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                {fz, fs, fv} = lfsr[2:0];
            end else begin
                {fz, fs, fv} = f_fix;
            end
            m_taken = 0;
            case (mph)
                0: begin mph = 1; m_tag = "R2"; end
                1: begin
                    b = mem[m_pc[7:0]];
                    if (b == 8'h90) begin m_pc = m_pc + 1; mph = 0; m_tag = "R3"; end
                    else if (b == 8'h7E || b == 8'h7F) begin m_op = b; mph = 2; m_tag = "R9"; end
                    else begin m_ill = 1; mph = 3; m_tag = "R8"; end
                end
                2: begin
                    b  = mem[8'(m_pc[7:0] + 8'd1)];
                    le = fz || (fs != fv);
                    gt = !fz && (fs == fv);
                    go = (m_op == 8'h7F) ? gt : le;
                    if (go) begin
                        m_pc = m_pc + 32'd2 + {{24{b[7]}}, b};
                        m_taken = 1; m_tag = "R5";
                    end else begin
                        m_pc = m_pc + 32'd2; m_tag = "R6";
                    end
                    mph = 0;
                end
                default: m_tag = "R8";
            endcase
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold_reset(logic [2:0] flags);
        rst_n = 1'b0;
        flag_rand = 1'b0;
        f_fix = flags;
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 8'h90;
    endtask

    task automatic release_reset(logic [31:0] start);
        start_addr = start;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 pc", pc, start);
        chk("R1 addr", rd_addr, start);
        chk("R1 taken", {31'b0, branch_taken}, 32'd0);
        chk("R1 illegal", {31'b0, illegal_op}, 32'd0);
    endtask

    task automatic steps(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        // T1: worked example, zero flag set (flags order z,s,v)
        hold_reset(3'b100);
        mem[8'h9C] = 8'h7E; mem[8'h9D] = 8'h0D;
        mem[8'hAB] = 8'h90;
        mem[8'hAC] = 8'h7F; mem[8'hAD] = 8'hFE;
        mem[8'hAE] = 8'h7E; mem[8'hAF] = 8'hFE;
        release_reset(32'h9C);
        steps(3);
        chk("R5 jle 0x9C+0x0D target", pc, 32'hAB);
        chk("R5 taken pulse", {31'b0, branch_taken}, 32'd1);
        steps(2);
        chk("R3 nop advance", pc, 32'hAC);
        steps(3);
        chk("R4 jg false with zero=1", pc, 32'hAE);
        chk("R6 no pulse", {31'b0, branch_taken}, 32'd0);
        steps(3);
        chk("R5 self loop 0xFE", pc, 32'hAE);
        chk("R5 self loop pulse", {31'b0, branch_taken}, 32'd1);
        steps(1);
        chk("R5 pulse ends", {31'b0, branch_taken}, 32'd0);

        // T2: fall-through displacement, greater true (sign = overflow = 1)
        hold_reset(3'b011);
        mem[8'h40] = 8'h7F; mem[8'h41] = 8'h00;
        release_reset(32'h40);
        steps(3);
        chk("R5 disp 0x00 target", pc, 32'h42);
        chk("R4 jg true", {31'b0, branch_taken}, 32'd1);

        // T3: less-or-equal via sign != overflow, crossing the top of the space
        hold_reset(3'b010);
        mem[8'hFC] = 8'h7E; mem[8'hFD] = 8'h05;
        mem[8'h03] = 8'h7E; mem[8'h04] = 8'hF0;
        release_reset(32'hFFFF_FFFC);
        steps(3);
        chk("R7 forward wrap", pc, 32'h0000_0003);
        steps(3);
        chk("R7 backward wrap", pc, 32'hFFFF_FFF5);

        // T4: unknown opcode after a no-operation
        hold_reset(3'b000);
        mem[8'h10] = 8'h90; mem[8'h11] = 8'h00;
        release_reset(32'h10);
        steps(3);
        chk("R8 not yet flagged", {31'b0, illegal_op}, 32'd0);
        steps(1);
        chk("R8 flag raised", {31'b0, illegal_op}, 32'd1);
        chk("R8 pc at bad opcode", pc, 32'h11);
        steps(20);
        chk("R8 flag sticky", {31'b0, illegal_op}, 32'd1);
        chk("R8 pc frozen", pc, 32'h11);
        chk("R8 addr frozen", rd_addr, 32'h11);

        // T5: long run over legal bytes only, pseudo-random flags
        hold_reset(3'b000);
        for (int i = 0; i < 256; i++) begin
            case ((i * 37 + 11) % 3)
                0: mem[i] = 8'h90;
                1: mem[i] = 8'h7E;
                default: mem[i] = 8'h7F;
            endcase
        end
        release_reset(32'h0);
        flag_rand = 1'b1;
        n_taken_seen = 0;
        steps(3000);
        n_cmp++;
        if (n_taken_seen == 0) begin
            n_bad++;
            $display("FAIL R4 random run: actual taken count=0 expected >0");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule